// File: doc/BRIEF.md
# Wait-Instruction Trap Router

This block decides whether a wait-for-interrupt or wait-for-event instruction is to be trapped, and at which privilege level the trap is taken. The caller supplies the level it wants the trap checked against, the current level, an event-or-interrupt flag, the trap controls held at privilege levels 1, 2 and 3, the level-2 enable and host-routing bits, and a 5-bit condition code. All of these inputs are captured on a request strobe. One clock later the block presents its result for exactly one cycle.

The result is one of three outcomes. The first is a trap pulse, which comes with the final destination level and a 25-bit syndrome word. The second is an error pulse, raised when the request was not legal. The third is silence, when the instruction is allowed to run. The level-1 controls are active-low: a 0 bit means trap. The level-2 and level-3 controls are active-high. A level-1 trap is redirected to level 2 when level 2 is enabled and host routing is set. Entering the exception and the low-power wait itself are handled elsewhere.

Top module: `wfx_trap_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, trap_vld_o and bad_req_o are 0, and trap_lvl_o and synd_o are zero.
- R2: A legal request with target level 1 traps when the level-1 allow bit for the instruction kind is 0. That bit is l1_evt_ok_i for an event wait and l1_int_ok_i for an interrupt wait. The level-1 allow bit for the other instruction kind has no effect on the result.
- R3: A legal request with target level 2 traps when the level-2 trap bit for the instruction kind is 1. That bit is l2_evt_trap_i for an event wait and l2_int_trap_i for an interrupt wait.
- R4: A legal request with target level 3 traps when the level-3 trap bit for the instruction kind is 1. That bit is l3_evt_trap_i for an event wait and l3_int_trap_i for an interrupt wait.
- R5: A request is legal only if its target level is numerically greater than its current level. An illegal request pulses bad_req_o and never produces a trap.
- R6: A request with target level 0 is always illegal. It gives bad_req_o = 1 and trap_vld_o = 0.
- R7: When a trap fires, synd_o[24:20] equals the condition code captured with the request and synd_o[19:1] is zero. synd_o[0] is 1 for an event wait and 0 for an interrupt wait.
- R8: A trap with target level 1 is reported with trap_lvl_o = 2 when l2_on_i = 1 and host_route_i = 1. In every other case trap_lvl_o equals the target level.
- R9: Results appear in the cycle after the cycle in which req_i is high, and they last for one cycle only. In a cycle that follows a cycle without a request, all outputs are zero.
- R10: A legal request that does not trap gives zero on all outputs. Whenever trap_vld_o = 0, trap_lvl_o and synd_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; all other inputs are sampled on this |
| tgt_lvl_i | input | 2 | Target level the trap is checked against |
| cur_lvl_i | input | 2 | Current privilege level |
| is_evt_i | input | 1 | 1 = event wait, 0 = interrupt wait |
| l1_evt_ok_i | input | 1 | Level-1 allow bit for event wait (0 = trap) |
| l1_int_ok_i | input | 1 | Level-1 allow bit for interrupt wait (0 = trap) |
| l2_evt_trap_i | input | 1 | Level-2 trap bit for event wait (1 = trap) |
| l2_int_trap_i | input | 1 | Level-2 trap bit for interrupt wait (1 = trap) |
| l3_evt_trap_i | input | 1 | Level-3 trap bit for event wait (1 = trap) |
| l3_int_trap_i | input | 1 | Level-3 trap bit for interrupt wait (1 = trap) |
| l2_on_i | input | 1 | Level 2 is enabled |
| host_route_i | input | 1 | Host routing: send level-1 traps to level 2 |
| cond_i | input | 5 | Condition code copied into the syndrome |
| trap_vld_o | output | 1 | One-cycle trap pulse |
| trap_lvl_o | output | 2 | Final destination level of the trap |
| synd_o | output | 25 | Syndrome word |
| bad_req_o | output | 1 | One-cycle pulse for an illegal request |

## Verification
The assertions assume the inputs matter only in a cycle where req_i is high, so any value is allowed in the other cycles. They also assume each result is judged against the inputs captured in the cycle before it. The stimulus breaks this on purpose: it changes every input on every cycle and puts idle cycles between requests, so a design that reads inputs without a request shows up as an error. Every pair of target level and current level is driven, including target 0 and target equal to current. The redirect is driven with every combination of level-2 enable and host routing.

// File: rtl/wfx_trap_pkg.sv
package wfx_trap_pkg;
    parameter int LVL_W  = 2;
    parameter int COND_W = 5;
    parameter int SYND_W = 25;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_USER = lvl_t'(0);
    localparam lvl_t LVL_KERN = lvl_t'(1);
    localparam lvl_t LVL_HYP  = lvl_t'(2);
    localparam lvl_t LVL_MON  = lvl_t'(3);
endpackage

// File: rtl/wfx_trap_decide.sv
module wfx_trap_decide
    import wfx_trap_pkg::*;
(
    input  lvl_t tgt_lvl_i,
    input  lvl_t cur_lvl_i,
    input  logic is_evt_i,
    input  logic l1_evt_ok_i,
    input  logic l1_int_ok_i,
    input  logic l2_evt_trap_i,
    input  logic l2_int_trap_i,
    input  logic l3_evt_trap_i,
    input  logic l3_int_trap_i,
    output logic legal_o,
    output logic trap_o
);
    localparam int NUM_LVL = 1 << LVL_W;

    logic [NUM_LVL-1:0] lvl_trap;

    // Per-level trap decision; level 1 is active-low, higher levels active-high.
    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            if (g == 0) begin : g_user
                assign lvl_trap[g] = 1'b0;
            end else if (g == 1) begin : g_kern
                assign lvl_trap[g] = ~(is_evt_i ? l1_evt_ok_i : l1_int_ok_i);
            end else if (g == 2) begin : g_hyp
                assign lvl_trap[g] = is_evt_i ? l2_evt_trap_i : l2_int_trap_i;
            end else begin : g_mon
                assign lvl_trap[g] = is_evt_i ? l3_evt_trap_i : l3_int_trap_i;
            end
        end
    endgenerate

    always_comb begin
        legal_o = (tgt_lvl_i != LVL_USER) && (tgt_lvl_i > cur_lvl_i);
        trap_o  = legal_o && lvl_trap[tgt_lvl_i];
    end
endmodule

// File: rtl/wfx_trap_route.sv
module wfx_trap_route
    import wfx_trap_pkg::*;
(
    input  lvl_t tgt_lvl_i,
    input  logic l2_on_i,
    input  logic host_route_i,
    output lvl_t dst_lvl_o
);
    always_comb begin
        if (tgt_lvl_i == LVL_KERN && l2_on_i && host_route_i) begin
            dst_lvl_o = LVL_HYP;
        end else begin
            dst_lvl_o = tgt_lvl_i;
        end
    end
endmodule

// File: rtl/wfx_synd_pack.sv
module wfx_synd_pack
    import wfx_trap_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic              is_evt_i,
    output logic [SYND_W-1:0] synd_o
);
    localparam int MID_W = SYND_W - COND_W - 1;

    always_comb begin
        synd_o = {cond_i, {MID_W{1'b0}}, is_evt_i};
    end
endmodule

// File: rtl/wfx_trap_router.sv
module wfx_trap_router
    import wfx_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        tgt_lvl_i,
    input  logic [1:0]        cur_lvl_i,
    input  logic              is_evt_i,
    input  logic              l1_evt_ok_i,
    input  logic              l1_int_ok_i,
    input  logic              l2_evt_trap_i,
    input  logic              l2_int_trap_i,
    input  logic              l3_evt_trap_i,
    input  logic              l3_int_trap_i,
    input  logic              l2_on_i,
    input  logic              host_route_i,
    input  logic [4:0]        cond_i,
    output logic              trap_vld_o,
    output logic [1:0]        trap_lvl_o,
    output logic [24:0]       synd_o,
    output logic              bad_req_o
);
    typedef struct packed {
        logic              vld;
        logic              bad;
        lvl_t              lvl;
        logic [SYND_W-1:0] synd;
    } res_t;

    res_t res_d, res_q;

    logic              legal, trap;
    lvl_t              dst_lvl;
    logic [SYND_W-1:0] synd;

    wfx_trap_decide u_decide (
        .tgt_lvl_i     (tgt_lvl_i),
        .cur_lvl_i     (cur_lvl_i),
        .is_evt_i      (is_evt_i),
        .l1_evt_ok_i   (l1_evt_ok_i),
        .l1_int_ok_i   (l1_int_ok_i),
        .l2_evt_trap_i (l2_evt_trap_i),
        .l2_int_trap_i (l2_int_trap_i),
        .l3_evt_trap_i (l3_evt_trap_i),
        .l3_int_trap_i (l3_int_trap_i),
        .legal_o       (legal),
        .trap_o        (trap)
    );

    wfx_trap_route u_route (
        .tgt_lvl_i    (tgt_lvl_i),
        .l2_on_i      (l2_on_i),
        .host_route_i (host_route_i),
        .dst_lvl_o    (dst_lvl)
    );

    wfx_synd_pack u_synd (
        .cond_i   (cond_i),
        .is_evt_i (is_evt_i),
        .synd_o   (synd)
    );

    always_comb begin
        res_d = '0;
        if (req_i) begin
            res_d.bad = ~legal;
            if (trap) begin
                res_d.vld  = 1'b1;
                res_d.lvl  = dst_lvl;
                res_d.synd = synd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign trap_vld_o = res_q.vld;
    assign bad_req_o  = res_q.bad;
    assign trap_lvl_o = res_q.lvl;
    assign synd_o     = res_q.synd;
endmodule

// File: rtl/wfx_trap_router_chk.sv
module wfx_trap_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [1:0]  tgt_lvl_i,
    input logic [1:0]  cur_lvl_i,
    input logic        is_evt_i,
    input logic        l3_evt_trap_i,
    input logic        l3_int_trap_i,
    input logic [4:0]  cond_i,
    input logic        trap_vld_o,
    input logic [1:0]  trap_lvl_o,
    input logic [24:0] synd_o,
    input logic        bad_req_o
);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!trap_vld_o && !bad_req_o));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_vld_o && bad_req_o));

    p_not_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && tgt_lvl_i <= cur_lvl_i) |=> (bad_req_o && !trap_vld_o));

    p_user_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && tgt_lvl_i == 2'd0) |=> bad_req_o);

    p_mid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld_o |-> (synd_o[19:1] == 19'd0));

    p_cond_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (!trap_vld_o || synd_o[24:20] == $past(cond_i)));

    p_kind_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (!trap_vld_o || synd_o[0] == $past(is_evt_i)));

    p_mon_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && tgt_lvl_i == 2'd3 && cur_lvl_i != 2'd3 &&
         (is_evt_i ? l3_evt_trap_i : l3_int_trap_i)) |=> (trap_vld_o && trap_lvl_o == 2'd3));

    p_dst_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld_o |-> (trap_lvl_o != 2'd0));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_vld_o |-> (trap_lvl_o == 2'd0 && synd_o == 25'd0));
endmodule

bind wfx_trap_router wfx_trap_router_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .tgt_lvl_i     (tgt_lvl_i),
    .cur_lvl_i     (cur_lvl_i),
    .is_evt_i      (is_evt_i),
    .l3_evt_trap_i (l3_evt_trap_i),
    .l3_int_trap_i (l3_int_trap_i),
    .cond_i        (cond_i),
    .trap_vld_o    (trap_vld_o),
    .trap_lvl_o    (trap_lvl_o),
    .synd_o        (synd_o),
    .bad_req_o     (bad_req_o)
);

// File: tb/sim_wfx_trap_router.sv
module sim_wfx_trap_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  tgt_lvl_i = '0, cur_lvl_i = '0;
    logic        is_evt_i = 1'b0;
    logic        l1_evt_ok_i = 1'b1, l1_int_ok_i = 1'b1;
    logic        l2_evt_trap_i = 1'b0, l2_int_trap_i = 1'b0;
    logic        l3_evt_trap_i = 1'b0, l3_int_trap_i = 1'b0;
    logic        l2_on_i = 1'b0, host_route_i = 1'b0;
    logic [4:0]  cond_i = '0;
    logic        trap_vld_o, bad_req_o;
    logic [1:0]  trap_lvl_o;
    logic [24:0] synd_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Expected outputs for the next sample point.
    int    e_vld, e_bad, e_lvl, e_synd;
    string e_tag;

    always #5 clk = ~clk;

    wfx_trap_router u0 (.*);

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model: compute what the block must show one cycle after this drive.
    task automatic model();
        int t, c, kind, fire;
        t = int'(tgt_lvl_i);
        c = int'(cur_lvl_i);
        kind = int'(is_evt_i);
        e_vld = 0; e_bad = 0; e_lvl = 0; e_synd = 0;
        if (!req_i) begin
            e_tag = "R9";
            return;
        end
        if (t == 0) begin
            e_bad = 1; e_tag = "R6"; return;
        end
        if (t <= c) begin
            e_bad = 1; e_tag = "R5"; return;
        end
        case (t)
            1: fire = kind ? (l1_evt_ok_i == 0) : (l1_int_ok_i == 0);
            2: fire = kind ? (l2_evt_trap_i == 1) : (l2_int_trap_i == 1);
            default: fire = kind ? (l3_evt_trap_i == 1) : (l3_int_trap_i == 1);
        endcase
        if (t == 1) e_tag = "R2"; else if (t == 2) e_tag = "R3"; else e_tag = "R4";
        if (!fire) begin
            e_tag = "R10"; return;
        end
        e_vld = 1;
        e_lvl = t;
        if (t == 1 && l2_on_i && host_route_i) begin
            e_lvl = 2; e_tag = "R8";
        end
        e_synd = int'(cond_i) * (1 << 20) + kind;
    endtask

    task automatic compare();
        check(e_tag, "trap_vld", int'(trap_vld_o), e_vld);
        check(e_tag, "bad_req", int'(bad_req_o), e_bad);
        check(e_tag, "trap_lvl", int'(trap_lvl_o), e_lvl);
        check("R7", "synd", int'(synd_o), e_synd);
    endtask

    task automatic step(input bit rq, input int t, input int c, input bit ev,
                        input bit a1e, input bit a1i, input bit b2e, input bit b2i,
                        input bit b3e, input bit b3i, input bit on2, input bit hr,
                        input int cd);
        req_i = rq; tgt_lvl_i = 2'(t); cur_lvl_i = 2'(c); is_evt_i = ev;
        l1_evt_ok_i = a1e; l1_int_ok_i = a1i; l2_evt_trap_i = b2e; l2_int_trap_i = b2i;
        l3_evt_trap_i = b3e; l3_int_trap_i = b3i; l2_on_i = on2; host_route_i = hr;
        cond_i = 5'(cd);
        model();
        @(negedge clk);
        compare();
    endtask

    task automatic rnd_step(input bit rq);
        logic [15:0] r;
        r = 16'($urandom);
        step(rq, int'(r[1:0]), int'(r[3:2]), r[4], r[5], r[6], r[7], r[8], r[9], r[10],
             r[11], r[12], int'($urandom) & 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset outputs
        check("R1", "trap_vld", int'(trap_vld_o), 0);
        check("R1", "bad_req", int'(bad_req_o), 0);
        check("R1", "synd", int'(synd_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "trap_lvl", int'(trap_lvl_o), 0);

        // R2: level 1, the other kind's allow bit must not matter
        step(1, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 5'h0A);
        step(1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 5'h0B);
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 5'h1F);
        step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 5'h01);
        // R8: redirect only with both bits
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 5'h11);
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 5'h12);
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 5'h13);
        step(1, 2, 1, 1, 1, 1, 1, 0, 0, 0, 1, 1, 5'h14);
        // R3, R4
        step(1, 2, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 5'h03);
        step(1, 2, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0, 5'h04);
        step(1, 3, 2, 0, 1, 1, 0, 0, 0, 1, 0, 0, 5'h15);
        step(1, 3, 0, 1, 0, 0, 1, 1, 0, 1, 0, 0, 5'h16);
        // R5, R6: illegal requests with all traps armed
        step(1, 2, 2, 1, 0, 0, 1, 1, 1, 1, 0, 0, 5'h1E);
        step(1, 1, 3, 0, 0, 0, 1, 1, 1, 1, 1, 1, 5'h1D);
        step(1, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 5'h1C);
        step(1, 3, 3, 1, 0, 0, 1, 1, 1, 1, 0, 0, 5'h1B);
        // R9: armed inputs without a request
        step(0, 1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 5'h1F);
        step(0, 3, 0, 1, 0, 0, 1, 1, 1, 1, 0, 0, 5'h1F);
        // Mixed traffic with idle gaps
        for (int i = 0; i < 3000; i++) begin
            rnd_step(($urandom % 4) != 0);
        end
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule